// File: doc/BRIEF.md
# Row Reconfiguration Loader and Phase Sequencer

This block loads a new configuration for a row of processing elements and sequences the row through its operating phases. Three serial lines are loaded in parallel, each into its own shadow shift chain with its own length. The first carries a 64-bit constant for every element. The second carries the operand-selector fields. The third carries the switch settings of the routing fabric between rows. Once every chain holds exactly its full length of bits, all three shadow chains are copied to the active configuration outputs in one clock edge. The active outputs feed the datapath.

A host controls the phases through request pulses. A reconfiguration request moves the sequencer from idle to loading. A completed load commits the configuration and parks the sequencer in a waiting phase. An execution request then starts execution, and an end-of-execution pulse returns the sequencer to idle. An execution request that arrives while loading is remembered and acted on right after the commit. An abort pulse during loading discards the partial load and leaves the previously committed configuration in place.

Top module: `cfg_loader_top`

## Requirements
- R1: After synchronous reset the sequencer is idle. `busy`, `exec_active` and `cfg_ready` are 0 and all three active configuration outputs are zero.
- R2: A `reconf_req` pulse while idle or waiting enters the loading phase (`busy`=1, `exec_active`=0) and empties all three shadow chains and bit counters.
- R3: While loading, each stream shifts one bit per clock when its enable is high. The first bit received ends up in the most significant position. Chain lengths are 64·W for constants, 3·ceil(log2(2·(2·MCL+1)))·W for selectors (24 with defaults W=2, MCL=2) and SW_BITS for switches (40 by default). Bits offered after a chain is full are ignored.
- R4: The commit happens only on the first edge at which all three chains are full. On that edge all three active outputs are updated together. `cfg_ready` is high for exactly the one cycle after the commit edge, and the sequencer is then waiting (`busy`=1, `exec_active`=0).
- R5: An `exec_req` pulse while waiting enters execution on the next edge, and `exec_active` stays 1 for the whole execution phase.
- R6: An `exec_req` received during loading is held. Execution starts on the edge after the commit without a further request.
- R7: `exec_end` during execution returns the sequencer to idle (`busy`=0). A `reconf_req` during execution is ignored: execution continues and the active outputs do not change.
- R8: `abort` during loading returns the sequencer to idle on the next edge without a commit and without a `cfg_ready` pulse. The active outputs keep their previous values, and a later load starts from empty chains.
- R9: The active outputs change only on a commit edge. While a load is in progress they keep the last committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reconf_req | input | 1 | Request to start loading a new configuration |
| exec_req | input | 1 | Request to start execution |
| exec_end | input | 1 | Execution finished |
| abort | input | 1 | Abandon the load in progress |
| imm_bit | input | 1 | Serial constant stream data |
| imm_en | input | 1 | Constant stream bit valid |
| sel_bit | input | 1 | Serial selector stream data |
| sel_en | input | 1 | Selector stream bit valid |
| sw_bit | input | 1 | Serial switch stream data |
| sw_en | input | 1 | Switch stream bit valid |
| imm_cfg | output | 64·W | Active constants, element 0 in the low word |
| sel_cfg | output | 3·SELB·W | Active selector fields |
| sw_cfg | output | SW_BITS | Active routing switch settings |
| cfg_ready | output | 1 | One-cycle pulse after a commit |
| exec_active | output | 1 | High during execution |
| busy | output | 1 | High whenever the sequencer is not idle |

## Verification
The hardest situation to reach from the ports is a commit where the three streams finish at different times. The short selector stream fills first and is then offered extra junk bits. Only the long constant stream decides when the commit happens. The bench drives all three lines together for the full constant length and keeps the selector and switch enables high past their own lengths. It then compares every active bit against the first bits sent. It also places a held execution request and an abort at chosen cycles inside a load, so that both the deferred start and the discarded partial load can be observed at the outputs.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam int IMM_WORD   = 64;
    localparam int SEL_FIELDS = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_WAIT = 2'd2,
        PH_EXEC = 2'd3
    } phase_t;

    typedef struct packed {
        logic clear;
        logic shift_ok;
        logic commit;
    } chain_ctl_t;

    function automatic int sel_field_bits(input int mcl);
        return $clog2(2 * (2 * mcl + 1));
    endfunction

endpackage

// File: rtl/cfgseq_chain.sv
module cfgseq_chain
    import cfgseq_pkg::*;
#(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  chain_ctl_t     ctl,
    input  logic           bit_in,
    input  logic           bit_en,
    output logic [LEN-1:0] active,
    output logic           full
);
    localparam int CW = $clog2(LEN + 1);

    logic [LEN-1:0] shadow;
    logic [CW-1:0]  cnt;
    logic           take;

    assign full = (cnt == CW'(LEN));
    assign take = ctl.shift_ok && bit_en && !full;

    logic [LEN-1:0] shifted;
    generate
        if (LEN == 1) begin : g_single
            assign shifted = bit_in;
        end else begin : g_multi
            assign shifted = {shadow[LEN-2:0], bit_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            shadow <= '0;
            cnt    <= '0;
        end else if (take) begin
            shadow <= shifted;
            cnt    <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (ctl.commit) begin
            active <= shadow;
        end
    end

endmodule

// File: rtl/cfgseq_phase_ctl.sv
module cfgseq_phase_ctl
    import cfgseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reconf_req,
    input  logic       exec_req,
    input  logic       exec_end,
    input  logic       abort,
    input  logic       all_full,
    output phase_t     phase,
    output chain_ctl_t ctl,
    output logic       cfg_ready,
    output logic       exec_active,
    output logic       busy
);
    phase_t nxt;
    logic   pend;

    always_comb begin
        nxt = phase;
        ctl = '0;
        unique case (phase)
            PH_IDLE: begin
                if (reconf_req) begin
                    nxt       = PH_LOAD;
                    ctl.clear = 1'b1;
                end
            end
            PH_LOAD: begin
                if (abort) begin
                    nxt       = PH_IDLE;
                    ctl.clear = 1'b1;
                end else begin
                    ctl.shift_ok = 1'b1;
                    if (all_full) begin
                        nxt        = PH_WAIT;
                        ctl.commit = 1'b1;
                    end
                end
            end
            PH_WAIT: begin
                if (exec_req || pend) begin
                    nxt = PH_EXEC;
                end else if (reconf_req) begin
                    nxt       = PH_LOAD;
                    ctl.clear = 1'b1;
                end
            end
            PH_EXEC: begin
                if (exec_end) nxt = PH_IDLE;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            pend      <= 1'b0;
            cfg_ready <= 1'b0;
        end else begin
            phase     <= nxt;
            cfg_ready <= ctl.commit;
            if (ctl.clear || nxt == PH_EXEC) begin
                pend <= 1'b0;
            end else if (phase == PH_LOAD && exec_req) begin
                pend <= 1'b1;
            end
        end
    end

    assign exec_active = (phase == PH_EXEC);
    assign busy        = (phase != PH_IDLE);

endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top
    import cfgseq_pkg::*;
#(
    parameter int W       = 2,
    parameter int MCL     = 2,
    parameter int SW_BITS = 40
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      reconf_req,
    input  logic                                      exec_req,
    input  logic                                      exec_end,
    input  logic                                      abort,
    input  logic                                      imm_bit,
    input  logic                                      imm_en,
    input  logic                                      sel_bit,
    input  logic                                      sel_en,
    input  logic                                      sw_bit,
    input  logic                                      sw_en,
    output logic [IMM_WORD*W-1:0]                     imm_cfg,
    output logic [SEL_FIELDS*sel_field_bits(MCL)*W-1:0] sel_cfg,
    output logic [SW_BITS-1:0]                        sw_cfg,
    output logic                                      cfg_ready,
    output logic                                      exec_active,
    output logic                                      busy
);
    localparam int SELB    = sel_field_bits(MCL);
    localparam int IMM_LEN = IMM_WORD * W;
    localparam int SEL_LEN = SEL_FIELDS * SELB * W;

    phase_t     phase;
    chain_ctl_t ctl;
    logic       imm_full, sel_full, sw_full;
    logic       all_full;

    assign all_full = imm_full && sel_full && sw_full;

    cfgseq_phase_ctl i_seq (
        .clk        (clk),
        .rst        (rst),
        .reconf_req (reconf_req),
        .exec_req   (exec_req),
        .exec_end   (exec_end),
        .abort      (abort),
        .all_full   (all_full),
        .phase      (phase),
        .ctl        (ctl),
        .cfg_ready  (cfg_ready),
        .exec_active(exec_active),
        .busy       (busy)
    );

    cfgseq_chain #(.LEN(IMM_LEN)) i_imm (
        .clk(clk), .rst(rst), .ctl(ctl), .bit_in(imm_bit), .bit_en(imm_en),
        .active(imm_cfg), .full(imm_full)
    );

    cfgseq_chain #(.LEN(SEL_LEN)) i_sel (
        .clk(clk), .rst(rst), .ctl(ctl), .bit_in(sel_bit), .bit_en(sel_en),
        .active(sel_cfg), .full(sel_full)
    );

    cfgseq_chain #(.LEN(SW_BITS)) i_sw (
        .clk(clk), .rst(rst), .ctl(ctl), .bit_in(sw_bit), .bit_en(sw_en),
        .active(sw_cfg), .full(sw_full)
    );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
    import cfgseq_pkg::*;
#(
    parameter int IMM_LEN = 128,
    parameter int SEL_LEN = 24,
    parameter int SW_LEN  = 40
) (
    input logic               clk,
    input logic               rst,
    input phase_t             phase,
    input logic               abort,
    input logic               exec_end,
    input logic               all_full,
    input logic               cfg_ready,
    input logic               exec_active,
    input logic               busy,
    input logic [IMM_LEN-1:0] imm_cfg,
    input logic [SEL_LEN-1:0] sel_cfg,
    input logic [SW_LEN-1:0]  sw_cfg
);
    a_r4_ready_single: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |=> !cfg_ready);

    a_r4_commit_needs_full: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |-> $past(all_full) && phase == PH_WAIT);

    a_r9_hold_active: assert property (@(posedge clk) disable iff (rst)
        !cfg_ready |-> $stable(imm_cfg) && $stable(sel_cfg) && $stable(sw_cfg));

    a_r5_exec_from_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(exec_active) |-> $past(phase) == PH_WAIT);

    a_r7_exec_persists: assert property (@(posedge clk) disable iff (rst)
        exec_active && !exec_end |=> exec_active);

    a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
        phase == PH_LOAD && abort |=> !busy && !cfg_ready);

endmodule

bind cfg_loader_top cfg_loader_chk #(
    .IMM_LEN(IMM_LEN), .SEL_LEN(SEL_LEN), .SW_LEN(SW_BITS)
) i_chk (
    .clk(clk), .rst(rst), .phase(phase), .abort(abort), .exec_end(exec_end),
    .all_full(all_full), .cfg_ready(cfg_ready), .exec_active(exec_active),
    .busy(busy), .imm_cfg(imm_cfg), .sel_cfg(sel_cfg), .sw_cfg(sw_cfg)
);

// File: tb/test_cfg_loader_top.sv
module test_cfg_loader_top;
    localparam int IL = 128;
    localparam int SL = 24;
    localparam int WL = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reconf_req = 0, exec_req = 0, exec_end = 0, abort = 0;
    logic imm_bit = 0, imm_en = 0, sel_bit = 0, sel_en = 0, sw_bit = 0, sw_en = 0;
    logic [IL-1:0] imm_cfg;
    logic [SL-1:0] sel_cfg;
    logic [WL-1:0] sw_cfg;
    logic cfg_ready, exec_active, busy;

    int errors = 0;
    int checks = 0;
    logic [IL-1:0] e_imm = '0;
    logic [SL-1:0] e_sel = '0;
    logic [WL-1:0] e_sw  = '0;

    always #2 clk = ~clk;

    cfg_loader_top i_cfg_loader_top (
        .clk(clk), .rst(rst), .reconf_req(reconf_req), .exec_req(exec_req),
        .exec_end(exec_end), .abort(abort), .imm_bit(imm_bit), .imm_en(imm_en),
        .sel_bit(sel_bit), .sel_en(sel_en), .sw_bit(sw_bit), .sw_en(sw_en),
        .imm_cfg(imm_cfg), .sel_cfg(sel_cfg), .sw_cfg(sw_cfg),
        .cfg_ready(cfg_ready), .exec_active(exec_active), .busy(busy)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [IL-1:0] act, input logic [IL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_cfg(input string req);
        chk(imm_cfg == e_imm, req, "imm_cfg", imm_cfg, e_imm);
        chk(sel_cfg == e_sel, req, "sel_cfg", IL'(sel_cfg), IL'(e_sel));
        chk(sw_cfg == e_sw, req, "sw_cfg", IL'(sw_cfg), IL'(e_sw));
    endtask

    // Full load; exec_at >= 0 raises exec_req during that loading cycle.
    task automatic do_load(input logic [IL-1:0] im, input logic [SL-1:0] se,
                           input logic [WL-1:0] sw, input int exec_at);
        reconf_req = 1;
        @(negedge clk);
        reconf_req = 0;
        chk(busy && !exec_active, "R2", "enter loading", IL'({busy, exec_active}), IL'(2'b10));
        for (int k = 0; k < IL; k++) begin
            imm_en  = 1; imm_bit = im[IL-1-k];
            sel_en  = (k < 60);
            sel_bit = (k < SL) ? se[SL-1-k] : ~k[0];
            sw_en   = (k < 70);
            sw_bit  = (k < WL) ? sw[WL-1-k] : 1'b1;
            exec_req = (k == exec_at);
            @(negedge clk);
            if (k == 64) begin
                chk(!cfg_ready, "R9", "no ready mid-load", IL'(cfg_ready), '0);
                chk_cfg("R9");
            end
        end
        imm_en = 0; sel_en = 0; sw_en = 0; exec_req = 0;
        chk(!cfg_ready, "R4", "no commit before full edge", IL'(cfg_ready), '0);
        @(negedge clk);
        e_imm = im; e_sel = se; e_sw = sw;
        chk(cfg_ready, "R4", "ready pulse", IL'(cfg_ready), IL'(1));
        chk_cfg("R3");
        chk(!exec_active && busy, "R4", "waiting", IL'({busy, exec_active}), IL'(2'b10));
        @(negedge clk);
        chk(!cfg_ready, "R4", "pulse one cycle", IL'(cfg_ready), '0);
        if (exec_at >= 0)
            chk(exec_active, "R6", "held exec starts", IL'(exec_active), IL'(1));
        else
            chk(!exec_active && busy, "R4", "still waiting", IL'({busy, exec_active}), IL'(2'b10));
    endtask

    task automatic t_reset;
        chk(!busy && !exec_active && !cfg_ready, "R1", "flags",
            IL'({busy, exec_active, cfg_ready}), '0);
        chk_cfg("R1");
    endtask

    task automatic t_exec_cycle;
        exec_req = 1;
        @(negedge clk);
        exec_req = 0;
        chk(exec_active, "R5", "exec starts", IL'(exec_active), IL'(1));
        @(negedge clk);
        chk(exec_active, "R5", "exec holds", IL'(exec_active), IL'(1));
        reconf_req = 1;
        @(negedge clk);
        reconf_req = 0;
        @(negedge clk);
        chk(exec_active && busy, "R7", "reconf ignored in exec", IL'(exec_active), IL'(1));
        chk_cfg("R7");
        exec_end = 1;
        @(negedge clk);
        exec_end = 0;
        chk(!busy && !exec_active, "R7", "back to idle", IL'({busy, exec_active}), '0);
    endtask

    task automatic t_abort;
        reconf_req = 1;
        @(negedge clk);
        reconf_req = 0;
        for (int k = 0; k < 10; k++) begin
            imm_en = 1; imm_bit = 1; sel_en = 1; sel_bit = 1; sw_en = 1; sw_bit = 1;
            @(negedge clk);
        end
        imm_en = 0; sel_en = 0; sw_en = 0;
        abort = 1;
        @(negedge clk);
        abort = 0;
        chk(!busy && !cfg_ready, "R8", "idle after abort", IL'({busy, cfg_ready}), '0);
        chk_cfg("R8");
        @(negedge clk);
        chk(!cfg_ready, "R8", "no late commit", IL'(cfg_ready), '0);
        chk_cfg("R8");
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        do_load({64'h0123_4567_89AB_CDEF, 64'hF0E1_D2C3_B4A5_9687}, 24'hA5C33C,
                40'h12_3456_789A, -1);
        do_load({64'hDEAD_BEEF_0000_FFFF, 64'h8000_0000_0000_0001}, 24'h0F1E2D,
                40'hFF_0000_FF00, -1);
        t_exec_cycle();
        t_abort();
        do_load({64'h5555_AAAA_3333_CCCC, 64'h0F0F_F0F0_1248_8421}, 24'h800001,
                40'h80_0000_0001, 5);
        exec_end = 1;
        @(negedge clk);
        exec_end = 0;
        chk(!busy, "R7", "idle after held exec", IL'(busy), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule